// File: doc/BRIEF.md
# MFSK Peak Detector with Lock Check

This block makes the symbol decision for a non-coherent 16-tone frequency-shift-keyed receiver. At the end of every symbol period an upstream correlator delivers one power value per frequency bin. The values arrive serially, one per accepted cycle, and a start flag marks bin 0. The block tracks the strongest bin while the values stream in and sums all of them. Phase plays no part: only the power magnitudes are compared.

Once the last bin has been taken, the block checks whether the winning bin clearly dominates the rest. If it does, the bin index goes out as the decided symbol with a one-cycle valid strobe, and the lock flag is set. If it does not, the local spreading code is assumed to be misaligned with the received signal. The lock flag is cleared, no symbol is delivered, and a one-cycle request tells the code-phase shifter to try the next relative alignment. The number of bins, the power width and the strength of the dominance test are all parameters.

Top module: `mfsk_peak_detect`

## Requirements
- R1: Each frame holds NBINS bins (16 by default) indexed 0 to NBINS-1 in arrival order. The cycle after the edge that takes the last bin, a locked frame raises `sym_valid` for exactly one cycle, and `sym_out` then holds the index of the bin with the largest power.
- R2: When several bins share the largest power, the lowest index among them is the decided symbol.
- R3: Let S be the sum of all bins except the winning bin, and let DOM_SHIFT default to 2. A frame is locked when the peak power is strictly greater than S shifted right by DOM_SHIFT. The decision cycle of a locked frame sets `lock` to 1.
- R4: A frame that fails the test of R3 sets `lock` to 0 and raises `shift_req` for exactly one cycle in the decision cycle. It gives no `sym_valid`, and `sym_out` keeps the last locked symbol.
- R5: A frame whose bins are all zero fails the test of R3.
- R6: A cycle with both `bin_valid` and `bin_first` high starts a new frame with that cycle's value as bin 0, even if a frame is already in progress. The bins of the abandoned frame have no effect.
- R7: A cycle with `bin_valid` low takes no bin and does not move the frame along. A cycle with `bin_valid` high and `bin_first` low is ignored when no frame is in progress.
- R8: While reset is asserted and right after it, `sym_out` is 0 and `sym_valid`, `lock` and `shift_req` are all 0.
- R9: `sym_valid` and `shift_req` are never high in the same cycle. Neither is high in two consecutive cycles.
- R10: `lock` changes only in a decision cycle and otherwise holds its value between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bin_valid | input | 1 | A bin power value is present this cycle |
| bin_first | input | 1 | The present value is bin 0 of a new frame |
| bin_power | input | PWR_W | Unsigned power of the present bin |
| sym_out | output | $clog2(NBINS) | Last decided symbol (index of the strongest bin) |
| sym_valid | output | 1 | One-cycle strobe: a new locked symbol is on sym_out |
| lock | output | 1 | Outcome of the latest dominance test |
| shift_req | output | 1 | One-cycle request to step the local code phase |

## Verification
The internal state is the bin counter, the running maximum with its index, and the running sum. A fault in any of them shows up at the decision cycle of the frame it affects. A counter that slips or misses a restart makes the strobe arrive in the wrong cycle, or appear for stray or abandoned bins. A wrong maximum or tie rule shows up in `sym_out`. A wrong sum, or a wrong comparison at the threshold edge, flips `lock` and swaps `sym_valid` for `shift_req`. The frames are chosen so that each such fault changes the result of the next frame, including frames exactly one unit on either side of the threshold.

// File: rtl/mfsk_pd_pkg.sv
package mfsk_pd_pkg;

   // Smallest legal frame and the widest power the accumulator supports.
   localparam int MIN_BINS  = 2;
   localparam int MAX_PWR_W = 32;

   // Unsigned greater-than with the lower index keeping ties.
   function automatic logic beats(input logic [MAX_PWR_W-1:0] cand,
                                  input logic [MAX_PWR_W-1:0] best);
      return cand > best;
   endfunction

endpackage

// File: rtl/mfsk_pd_seq.sv
module mfsk_pd_seq #(
   parameter int NBINS = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bin_valid,
   input  logic             bin_first,
   output logic             take,
   output logic             take_first,
   output logic             take_last,
   output logic [IDX_W-1:0] take_idx
);

   logic [IDX_W-1:0] cnt_q;
   logic             active_q;

   always_comb begin
      take       = bin_valid & (bin_first | active_q);
      take_first = bin_valid & bin_first;
      take_idx   = bin_first ? '0 : cnt_q;
      take_last  = take & (take_idx == IDX_W'(NBINS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (take) begin
         if (take_last) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
         end else begin
            cnt_q    <= take_idx + 1'b1;
            active_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mfsk_pd_peak.sv
module mfsk_pd_peak
   import mfsk_pd_pkg::*;
#(
   parameter int PWR_W = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             take_first,
   input  logic [IDX_W-1:0] take_idx,
   input  logic [PWR_W-1:0] bin_power,
   output logic [PWR_W-1:0] nxt_max,
   output logic [IDX_W-1:0] nxt_idx
);

   logic [PWR_W-1:0] max_q;
   logic [IDX_W-1:0] idx_q;

   always_comb begin
      nxt_max = max_q;
      nxt_idx = idx_q;
      if (take_first) begin
         nxt_max = bin_power;
         nxt_idx = '0;
      end else if (take && beats(MAX_PWR_W'(bin_power), MAX_PWR_W'(max_q))) begin
         nxt_max = bin_power;
         nxt_idx = take_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         max_q <= '0;
         idx_q <= '0;
      end else if (take) begin
         max_q <= nxt_max;
         idx_q <= nxt_idx;
      end
   end

endmodule

// File: rtl/mfsk_pd_sum.sv
module mfsk_pd_sum #(
   parameter int PWR_W = 16,
   parameter int SUM_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             take_first,
   input  logic [PWR_W-1:0] bin_power,
   output logic [SUM_W-1:0] nxt_sum
);

   logic [SUM_W-1:0] acc_q;

   always_comb begin
      if (take_first)
         nxt_sum = SUM_W'(bin_power);
      else if (take)
         nxt_sum = acc_q + SUM_W'(bin_power);
      else
         nxt_sum = acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (take)
         acc_q <= nxt_sum;
   end

endmodule

// File: rtl/mfsk_peak_detect.sv
module mfsk_peak_detect
   import mfsk_pd_pkg::*;
#(
   parameter int NBINS     = 16,
   parameter int PWR_W     = 16,
   parameter int DOM_SHIFT = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bin_valid,
   input  logic                     bin_first,
   input  logic [PWR_W-1:0]         bin_power,
   output logic [$clog2(NBINS)-1:0] sym_out,
   output logic                     sym_valid,
   output logic                     lock,
   output logic                     shift_req
);

   localparam int IDX_W = $clog2(NBINS);
   localparam int SUM_W = PWR_W + IDX_W;

   generate
      if (NBINS < MIN_BINS || (1 << IDX_W) != NBINS)
         $error("mfsk_peak_detect: NBINS must be a power of two, at least 2");
      if (PWR_W < 1 || PWR_W > MAX_PWR_W)
         $error("mfsk_peak_detect: PWR_W out of range");
      if (DOM_SHIFT < 0 || DOM_SHIFT >= SUM_W)
         $error("mfsk_peak_detect: DOM_SHIFT out of range");
   endgenerate

   logic             take, take_first, take_last;
   logic [IDX_W-1:0] take_idx;
   logic [PWR_W-1:0] nxt_max;
   logic [IDX_W-1:0] nxt_idx;
   logic [SUM_W-1:0] nxt_sum;
   logic [SUM_W-1:0] rest_sum;
   logic [SUM_W-1:0] thresh;
   logic             dominant;

   mfsk_pd_seq #(.NBINS(NBINS), .IDX_W(IDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .bin_valid  (bin_valid),
      .bin_first  (bin_first),
      .take       (take),
      .take_first (take_first),
      .take_last  (take_last),
      .take_idx   (take_idx)
   );

   mfsk_pd_peak #(.PWR_W(PWR_W), .IDX_W(IDX_W)) u_peak (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .take_first (take_first),
      .take_idx   (take_idx),
      .bin_power  (bin_power),
      .nxt_max    (nxt_max),
      .nxt_idx    (nxt_idx)
   );

   mfsk_pd_sum #(.PWR_W(PWR_W), .SUM_W(SUM_W)) u_sum (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .take_first (take_first),
      .bin_power  (bin_power),
      .nxt_sum    (nxt_sum)
   );

   assign rest_sum = nxt_sum - SUM_W'(nxt_max);

   generate
      if (DOM_SHIFT == 0) begin : g_thr_plain
         assign thresh = rest_sum;
      end else begin : g_thr_shift
         assign thresh = rest_sum >> DOM_SHIFT;
      end
   endgenerate

   assign dominant = SUM_W'(nxt_max) > thresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_out   <= '0;
         sym_valid <= 1'b0;
         lock      <= 1'b0;
         shift_req <= 1'b0;
      end else begin
         sym_valid <= take_last & dominant;
         shift_req <= take_last & ~dominant;
         if (take_last)
            lock <= dominant;
         if (take_last && dominant)
            sym_out <= nxt_idx;
      end
   end

endmodule

// File: rtl/mfsk_pd_chk.sv
module mfsk_pd_chk #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bin_valid,
   input logic [IDX_W-1:0] sym_out,
   input logic             sym_valid,
   input logic             lock,
   input logic             shift_req
);

   // R9: the two strobes exclude each other
   a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sym_valid && shift_req));

   // R9: each strobe lasts one cycle
   a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid |=> !sym_valid);
   a_r9_shift_single: assert property (@(posedge clk) disable iff (!rst_n)
      shift_req |=> !shift_req);

   // R3: a delivered symbol comes with lock set
   a_r3_valid_locked: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid |-> lock);

   // R4: a shift request comes with lock cleared
   a_r4_shift_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      shift_req |-> !lock);

   // R4: the symbol changes only with a valid strobe
   a_r4_sym_held: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_valid |-> $stable(sym_out));

   // R10: lock moves only in a decision cycle
   a_r10_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(sym_valid || shift_req) |-> $stable(lock));

   // R1: a decision follows a cycle in which a bin was taken
   a_r1_decision_after_bin: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid || shift_req) |-> $past(bin_valid));

endmodule

bind mfsk_peak_detect mfsk_pd_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bin_valid (bin_valid),
   .sym_out   (sym_out),
   .sym_valid (sym_valid),
   .lock      (lock),
   .shift_req (shift_req)
);

// File: tb/mfsk_peak_detect_tb.sv
module mfsk_peak_detect_tb;

   localparam int NB = 16;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bin_valid = 1'b0;
   logic          bin_first = 1'b0;
   logic [PW-1:0] bin_power = '0;
   logic [3:0]    sym_out;
   logic          sym_valid, lock, shift_req;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   int last_sym = 0;
   int pw [NB];
   bit prev_strobe = 1'b0;

   bit    q_lock [$];
   int    q_sym  [$];
   string q_req  [$];

   always #4 clk = ~clk;

   mfsk_peak_detect #(.NBINS(NB), .PWR_W(PW), .DOM_SHIFT(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bin_valid(bin_valid), .bin_first(bin_first),
      .bin_power(bin_power), .sym_out(sym_out), .sym_valid(sym_valid),
      .lock(lock), .shift_req(shift_req)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Driver: computes the expected decision from pw[] and sends the frame.
   task automatic send_frame(input int gap, input string req);
      int best = 0;
      int bidx = 0;
      int tot = 0;
      bit lk;
      for (int i = 0; i < NB; i++) begin
         tot += pw[i];
         if (pw[i] > best || i == 0) begin
            best = pw[i];
            bidx = i;
         end
      end
      lk = best > ((tot - best) >> 2);
      if (lk) last_sym = bidx;
      q_lock.push_back(lk);
      q_sym.push_back(last_sym);
      q_req.push_back(req);
      for (int i = 0; i < NB; i++) begin
         @(negedge clk);
         bin_valid = 1'b1;
         bin_first = (i == 0);
         bin_power = PW'(pw[i]);
         for (int g = 0; g < gap && i != NB - 1; g++) begin
            @(negedge clk);
            bin_valid = 1'b0;
            bin_first = 1'b0;
            bin_power = 16'hFFFF;
         end
      end
      @(negedge clk);
      bin_valid = 1'b0;
      bin_first = 1'b0;
      bin_power = '0;
   endtask

   task automatic fill(input int v);
      for (int i = 0; i < NB; i++) pw[i] = v;
   endtask

   // Monitor: pops an expectation for every decision strobe.
   always @(negedge clk) begin
      if (rst_n) begin
         bit strobe;
         strobe = sym_valid | shift_req;
         if (sym_valid && shift_req) check("R9 both strobes", 1, 0);
         if (strobe) begin
            check("R9 strobe width", int'(prev_strobe), 0);
            if (q_lock.size() == 0) begin
               check("R6/R7 unexpected decision", 1, 0);
            end else begin
               bit    el;
               int    es;
               string er;
               el = q_lock.pop_front();
               es = q_sym.pop_front();
               er = q_req.pop_front();
               check({er, " sym_valid"}, int'(sym_valid), int'(el));
               check({er, " shift_req R4"}, int'(shift_req), int'(!el));
               check({er, " lock R3"}, int'(lock), int'(el));
               check({er, " sym_out R1"}, int'(sym_out), es);
            end
         end
         prev_strobe = strobe;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         check("watchdog", 1, 0);
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 sym_out in reset", int'(sym_out), 0);
      check("R8 flags in reset", int'({sym_valid, lock, shift_req}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 sym_out after reset", int'(sym_out), 0);
      check("R8 flags after reset", int'({sym_valid, lock, shift_req}), 0);

      // R1/R3: strong peak at bin 5
      fill(10); pw[5] = 500;
      send_frame(0, "R1 peak5");
      // R1: peak at the last bin, then at bin 0
      fill(3); pw[15] = 900;
      send_frame(0, "R1 peak15");
      fill(7); pw[0] = 1000;
      send_frame(0, "R1 peak0");
      // R2: tie between bins 3 and 9
      fill(1); pw[3] = 800; pw[9] = 800;
      send_frame(0, "R2 tie");
      repeat (4) @(negedge clk);
      check("R10 lock held", int'(lock), 1);
      // R4: flat spectrum fails
      fill(100);
      send_frame(0, "R4 flat");
      repeat (4) @(negedge clk);
      check("R10 unlock held", int'(lock), 0);
      // R3 boundary: rest 60 >> 2 = 15
      fill(4); pw[7] = 15;
      send_frame(0, "R3 at threshold");
      fill(4); pw[7] = 16;
      send_frame(0, "R3 above threshold");
      // R5: all zero
      fill(0);
      send_frame(0, "R5 zeros");
      // R6: abandoned partial frame with a large peak at bin 2
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         bin_valid = 1'b1;
         bin_first = (i == 0);
         bin_power = (i == 2) ? 16'd60000 : 16'd5;
      end
      fill(2); pw[11] = 300;
      send_frame(0, "R6 restart");
      // R7: stray bins while idle are ignored
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         bin_valid = 1'b1;
         bin_first = 1'b0;
         bin_power = 16'd40000;
      end
      @(negedge clk);
      bin_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 stray bins ignored", q_lock.size(), 0);
      // R7: gaps inside the frame
      fill(6); pw[12] = 400;
      send_frame(2, "R7 gaps");
      fill(9); pw[4] = 30;
      send_frame(1, "R7 gaps unlocked");

      repeat (5) @(negedge clk);
      check("R1 all decisions seen", q_lock.size(), 0);
      summary();
   end

endmodule